// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Alignment Searcher

This block finds the CRC-4 multiframe boundary in an E1 receive stream after basic frame alignment is established. A per-frame strobe comes in with a flag that says whether the frame is a non-alignment frame, along with that frame's international bit (bit 1). The block gathers the international bits of the non-alignment frames and looks for the six-bit multiframe alignment word. It then decides whether the boundary it found can be trusted.

A two-bit mode input sets the confirmation rule. The search can be off, or it can need one, two or three alignment words inside a 64-frame (8 ms) window. When more than one word is needed, each accepted word must sit a whole number of multiframes (16 frames) after the previous one. Once sync is declared, the block gives a one-clock pulse on the strobe of frame 0 of every multiframe. The search restarts from scratch when the frame-aligned input drops, when the mode changes, or when the window runs out.

Top module: `crc4mf_align`

## Requirements
- R1: Mode 0 disables the search. `mf_sync` stays 0 and `mf_pulse` never asserts, whatever the input stream.
- R2: In mode 1, `mf_sync` goes to 1 on the clock edge that takes the strobe of the frame that completes one valid alignment word.
- R3: In mode 2, `mf_sync` goes to 1 only after two accepted words. Words that are 16, 32 or 48 frames apart are accepted.
- R4: In mode 3, `mf_sync` goes to 1 only after three accepted words, all inside one window.
- R5: A frame is a non-alignment frame when `frm_nfas` = 1. A word is valid only when the `si_bit` values of six successive non-alignment frames are, oldest first, 0,0,1,0,1,1. A word with any of those bits wrong is not counted.
- R6: In modes 2 and 3, a valid word whose distance in frames from the last accepted word is not a multiple of 16 does not count. It does not restart the search.
- R7: When the count of frames since the first accepted word reaches 64 before enough words are found, the count is dropped. A word that lands on that 64th frame becomes the new first word.
- R8: `mf_pulse` is combinational. It is high only during the strobe of multiframe frame 0, and only while sync is declared and the mode is not 0. The frame that completes a word is frame 11, so pulses come 5, 21, 37 ... strobes later.
- R9: When `fas_locked` is 0 at a clock edge, the search and `mf_sync` are cleared at that edge.
- R10: When `mode` changes, the search and `mf_sync` are cleared at the edge that first sees the new value.
- R11: After reset, `mf_sync` is 0 and `mf_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_stb | input | 1 | One-clock strobe per received E1 frame |
| frm_nfas | input | 1 | 1 = frame without the alignment signal (odd multiframe position) |
| si_bit | input | 1 | Bit 1 of the frame being strobed |
| fas_locked | input | 1 | Basic frame alignment is established |
| mode | input | 2 | 0 off, 1/2/3 = number of words needed |
| mf_sync | output | 1 | Multiframe alignment declared |
| mf_pulse | output | 1 | High during the strobe of multiframe frame 0 while in sync |

## Verification
The hardest case to reach from the ports is a word that lands exactly as the 64-frame window runs out. That word must restart the count as a new first word rather than complete the criterion. The stimulus places three words 32 frames apart in mode 3, so the third lands on frame 64, and places two words 64 frames apart in mode 2. Neither may reach sync. Off-spacing words are made by putting 8 filler frames between alignment multiframes. The frame-0 pulse is then checked on every strobe of the two multiframes that follow.

// File: rtl/crc4mf_pkg.sv
package crc4mf_pkg;

    typedef enum logic [1:0] {
        MF_OFF   = 2'd0,
        MF_ONE   = 2'd1,
        MF_TWO   = 2'd2,
        MF_THREE = 2'd3
    } mf_mode_e;

    localparam int unsigned WORD_LEN = 6;
    localparam logic [WORD_LEN-1:0] ALIGN_WORD = 6'b001011;

endpackage

// File: rtl/crc4mf_word_det.sv
module crc4mf_word_det #(
    parameter int unsigned W = 6,
    parameter logic [W-1:0] PAT = 6'b001011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic nfas,
    input  logic si,
    output logic hit
);

    typedef struct packed {
        logic [W-2:0] hist;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        if (clr) begin
            det_d.hist = '0;
        end else if (stb && nfas) begin
            det_d.hist = {det_q.hist[W-3:0], si};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign hit = stb && nfas && !clr && ({det_q.hist, si} == PAT);

endmodule

// File: rtl/crc4mf_pos_track.sv
module crc4mf_pos_track #(
    parameter int unsigned FPM      = 16,
    parameter int unsigned LAST_POS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic hit,
    input  logic en,
    output logic pulse
);

    localparam int unsigned PW = $clog2(FPM);

    typedef struct packed {
        logic [PW-1:0] pos;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (stb) begin
            if (hit)
                pos_d.pos = PW'(LAST_POS);
            else if (pos_q.pos == PW'(FPM - 1))
                pos_d.pos = '0;
            else
                pos_d.pos = pos_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pulse = en && stb && !hit && (pos_q.pos == PW'(FPM - 1));

endmodule

// File: rtl/crc4mf_align.sv
module crc4mf_align #(
    parameter int unsigned FPM    = 16,
    parameter int unsigned WIN_MF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_stb,
    input  logic       frm_nfas,
    input  logic       si_bit,
    input  logic       fas_locked,
    input  logic [1:0] mode,
    output logic       mf_sync,
    output logic       mf_pulse
);
    import crc4mf_pkg::*;

    localparam int unsigned WIN      = FPM * WIN_MF;
    localparam int unsigned SW       = $clog2(WIN);
    localparam int unsigned GW       = $clog2(FPM);
    localparam int unsigned LAST_POS = 2 * WORD_LEN - 1;

    typedef struct packed {
        logic [1:0]    mode;
        logic [1:0]    cnt;
        logic [SW-1:0] span;
        logic [GW-1:0] gap;
        logic          sync;
    } srch_t;

    srch_t s_d, s_q;
    logic  clr, hit, pulse;

    assign clr = !fas_locked || (mode != s_q.mode) || (mode == MF_OFF);

    crc4mf_word_det #(.W(WORD_LEN), .PAT(ALIGN_WORD)) u_det (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .stb  (frm_stb),
        .nfas (frm_nfas),
        .si   (si_bit),
        .hit  (hit)
    );

    crc4mf_pos_track #(.FPM(FPM), .LAST_POS(LAST_POS)) u_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (frm_stb),
        .hit  (hit),
        .en   (s_q.sync && !clr),
        .pulse(pulse)
    );

    always_comb begin
        s_d      = s_q;
        s_d.mode = mode;
        if (clr) begin
            s_d.cnt  = '0;
            s_d.span = '0;
            s_d.gap  = '0;
            s_d.sync = 1'b0;
        end else if (frm_stb && !s_q.sync) begin
            if (s_q.cnt == 2'd0) begin
                if (hit) begin
                    s_d.cnt  = 2'd1;
                    s_d.span = '0;
                    s_d.gap  = '0;
                    s_d.sync = (mode == 2'd1);
                end
            end else if (s_q.span == SW'(WIN - 1)) begin
                // window used up: restart, a word here becomes the new first one
                s_d.cnt  = hit ? 2'd1 : 2'd0;
                s_d.span = '0;
                s_d.gap  = '0;
            end else begin
                s_d.span = s_q.span + 1'b1;
                if (s_q.gap == GW'(FPM - 1)) begin
                    s_d.gap = '0;
                    if (hit) begin
                        s_d.cnt  = s_q.cnt + 1'b1;
                        s_d.sync = ((s_q.cnt + 2'd1) == mode);
                    end
                end else begin
                    s_d.gap = s_q.gap + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mf_sync  = s_q.sync;
    assign mf_pulse = pulse;

endmodule

// File: rtl/crc4mf_align_chk.sv
module crc4mf_align_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_stb,
    input logic       fas_locked,
    input logic [1:0] mode,
    input logic       mf_sync,
    input logic       mf_pulse
);

    // R1
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> !mf_sync);

    // R8
    pulse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pulse |-> (frm_stb && mf_sync && fas_locked && (mode != 2'd0)));

    // R9
    unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fas_locked |=> !mf_sync);

    // R10
    mode_change_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |=> !mf_sync);

    // R2
    sync_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_sync) |-> $past(frm_stb));

endmodule

bind crc4mf_align crc4mf_align_chk u_chk (.*);

// File: tb/crc4mf_align_tb.sv
`timescale 1ns/1ps
module crc4mf_align_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_stb = 1'b0;
    logic       frm_nfas = 1'b0;
    logic       si_bit = 1'b1;
    logic       fas_locked = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       mf_sync, mf_pulse;

    int checks = 0;
    int fails = 0;
    int fidx = 0;

    always #2 clk = ~clk;

    crc4mf_align u_dut (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_nfas(frm_nfas),
        .si_bit(si_bit), .fas_locked(fas_locked), .mode(mode),
        .mf_sync(mf_sync), .mf_pulse(mf_pulse)
    );

    localparam logic [5:0] WORD = 6'b001011;

    // {mode, words, gap frames between word multiframes, expected sync, requirement}
    localparam int NV = 10;
    localparam logic [14:0] VEC [NV] = '{
        {2'd1, 2'd1, 6'd0,  1'b1, 4'd2},  // R2 one word
        {2'd2, 2'd1, 6'd0,  1'b0, 4'd3},  // R3 one word not enough
        {2'd2, 2'd2, 6'd0,  1'b1, 4'd3},  // R3 span 16
        {2'd3, 2'd2, 6'd0,  1'b0, 4'd4},  // R4 two words not enough
        {2'd3, 2'd3, 6'd0,  1'b1, 4'd4},  // R4 spans 16
        {2'd2, 2'd2, 6'd8,  1'b0, 4'd6},  // R6 span 24 rejected
        {2'd3, 2'd3, 6'd16, 1'b0, 4'd7},  // R7 third word at frame 64
        {2'd2, 2'd2, 6'd32, 1'b1, 4'd3},  // R3 span 48
        {2'd0, 2'd3, 6'd0,  1'b0, 4'd1},  // R1 disabled
        {2'd2, 2'd2, 6'd48, 1'b0, 4'd7}   // R7 span 64 restarts
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (frame %0d)", req, act, exp, fidx);
        end
    endtask

    task automatic frame(input logic si, output logic pul);
        @(negedge clk);
        frm_stb  = 1'b1;
        frm_nfas = fidx[0];
        si_bit   = si;
        #1 pul = mf_pulse;
        @(negedge clk);
        frm_stb = 1'b0;
        si_bit  = 1'b1;
        fidx++;
    endtask

    task automatic fill(input int n);
        logic p;
        for (int i = 0; i < n; i++) frame(1'b1, p);
    endtask

    task automatic word_mf(input bit corrupt);
        logic p;
        logic b;
        for (int k = 0; k < 16; k++) begin
            b = 1'b1;
            if ((k % 2 == 1) && k <= 11) b = WORD[5 - (k - 1) / 2];
            if (corrupt && k == 5) b = ~b;
            frame(b, p);
        end
    endtask

    task automatic restart(input logic [1:0] m);
        fas_locked = 1'b0;
        fill(2);
        mode = m;
        fill(2);
        fas_locked = 1'b1;
    endtask

    task automatic pulse_scan(input string req, input logic exp_sync);
        logic p;
        for (int k = 0; k < 32; k++) begin
            frame(1'b1, p);
            check(req, p, exp_sync && (k % 16 == 0));
        end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", mf_sync, 1'b0);
        check("R11", mf_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", mf_sync, 1'b0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] vm;
            logic [1:0] vn;
            logic [5:0] vg;
            logic       ve;
            string      rq;
            {vm, vn, vg, ve} = VEC[v][14:4];
            rq = $sformatf("R%0d", VEC[v][3:0]);
            restart(vm);
            fill(4);
            for (int w = 0; w < vn; w++) begin
                if (w > 0) fill(vg);
                word_mf(1'b0);
            end
            check(rq, mf_sync, ve);
            pulse_scan(vm == 2'd0 ? "R1" : "R8", ve);
        end

        // R5 corrupted word is not counted
        restart(2'd1);
        fill(4);
        word_mf(1'b1);
        check("R5", mf_sync, 1'b0);
        word_mf(1'b0);
        check("R5", mf_sync, 1'b1);

        // R9 losing basic alignment clears sync
        fas_locked = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9", mf_sync, 1'b0);
        fas_locked = 1'b1;
        fill(2);
        check("R9", mf_sync, 1'b0);

        // R10 mode change clears sync
        restart(2'd1);
        fill(4);
        word_mf(1'b0);
        check("R10", mf_sync, 1'b1);
        mode = 2'd2;
        @(negedge clk);
        @(negedge clk);
        check("R10", mf_sync, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule